// File: doc/BRIEF.md
# Serial HEX Record Receiver with Address Guard

This block sits between a byte-wide serial receiver and an engine that programs on-chip program memory. It takes one ASCII character per `rx_valid` strobe, frames a text line that opens with a colon, turns each pair of hex digits into a byte and stores the whole line in a local buffer. When a carriage return or line feed closes the line, it checks the shape of the line and its checksum. Only after both checks pass does it hand the record on. A data record goes out as a sequence of 16-bit words, one address and one word per ready/valid transfer. A record that moves the upper address latches the new upper address. The end-of-file record stops the receiver.

While a line is being programmed, the block drops its clear-to-send output so the host waits. It raises clear-to-send again once the last word has been accepted. Words aimed at the first eight bytes of memory, where the user reset vector lives, are moved to a reserved tail area. Any record that would touch the protected loader area faults before a single word is sent.

Every error halts the block until reset. The error code and, where it applies, the record address stay visible on the outputs.

Top module: `rec_ingest`

## Requirements
- R1: After reset `cts` equals `host_rts`, `wr_valid`, `eof_done` and `halted` are 0, and `err_code` is 0.
- R2: Outside a record, every character other than ':' (0x3A) is ignored, CR (0x0D) and LF (0x0A) included. ':' opens a record. CR or LF closes it. Hex digits may be upper or lower case.
- R3: A record is accepted only if the 8-bit sum of all its bytes, checksum included, is zero. Otherwise `err_code`=1, `err_addr` holds the record start address, no word is sent and the block halts.
- R4: A type 0x00 record with N data bytes at start address A (A and N even) produces N/2 transfers. Transfer k carries address A+2k and data {byte 2k+1, byte 2k}, so the first byte is the low byte. `wr_valid` and the payload stay constant until `wr_ready` is seen.
- R5: A word whose byte address is below 8 is sent to address 0x7FF8 plus that address.
- R6: A type 0x00 record whose last byte address (start+N-1, counted without wrap) is 0x7C5C or above sets `err_code`=3 with `err_addr` = start address, halts, and sends nothing. Records ending at 0x7C5B are accepted.
- R7: A line is a format fault (`err_code`=2, `err_addr`=0, halt) in any of these cases: a non-hex character inside the record (faults at once), an odd number of digits, more than 21 bytes, fewer than 5 bytes, a length that differs from count+5, a data record with odd start or odd count, a type other than 00/01/04, a type 01 with count not 0, or a type 04 with count not 2. Shape faults take precedence over the checksum check.
- R8: `cts` is 0 from the cycle after a data line closes until the cycle after its last word is accepted. Characters that arrive in that window are ignored.
- R9: A valid type 0x01 record with count 0 sets `eof_done`=1 and holds `cts` at 0 until reset.
- R10: A valid type 0x04 record with data bytes D0, D1 sets `ext_hi` = {D0, D1} and returns to receiving.
- R11: `rx_overrun` in any state other than halted sets `err_code`=4, halts the block and drops `cts` and `wr_valid`.
- R12: Once halted, the block ignores all inputs and keeps its error outputs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One received character is present |
| rx_data | input | 8 | Received ASCII character |
| rx_overrun | input | 1 | Receiver lost a character |
| host_rts | input | 1 | Host has more data to send |
| cts | output | 1 | Host may send |
| wr_valid | output | 1 | A word is offered to the programming engine |
| wr_ready | input | 1 | Programming engine takes the word |
| wr_addr | output | 16 | Byte address of the word (after relocation) |
| wr_data | output | 16 | Word, first record byte in the low half |
| ext_hi | output | 16 | Latest upper address from a type 04 record |
| eof_done | output | 1 | End-of-file record accepted |
| err_code | output | 3 | 0 none, 1 checksum, 2 format, 3 overwrite, 4 overrun |
| err_addr | output | 16 | Record start address for checksum and overwrite faults |
| halted | output | 1 | Block stopped on an error |

## Verification
The bench sweeps data records over every even length from 0 to 16 bytes. Start addresses are chosen to cover three cases: fully inside the reset-vector window, straddling its upper edge, and in ordinary memory up to two bytes below the loader boundary. This shows whether remapping applies to exactly the words below byte 8, and whether the byte order inside a word is right. The same sweep is run with `wr_ready` held high and with `wr_ready` toggling, which checks that stalls neither drop nor repeat words. Single corrupted or malformed lines each exercise one fault rule, and each result is distinguished by its error code and address. An overrun in the middle of a line, followed by a well-formed line, shows that the halt sticks.

// File: rtl/rec_pkg.sv
// Shared codes for the HEX record receiver: error codes, control states,
// record types and the framing characters.
package rec_pkg;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0,
        ERR_CSUM = 3'd1,
        ERR_FMT  = 3'd2,
        ERR_OVW  = 3'd3,
        ERR_OVR  = 3'd4
    } rec_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LINE,
        ST_EMIT,
        ST_EOF,
        ST_HALT
    } rec_state_e;

    localparam logic [7:0] TYP_DATA = 8'h00;
    localparam logic [7:0] TYP_EOF  = 8'h01;
    localparam logic [7:0] TYP_EXT  = 8'h04;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

endpackage

// File: rtl/rec_char_class.sv
// Character classifier: sorts one ASCII character into hex digit, record
// opener or line end, and gives the nibble value of a hex digit.
// Assumes 8-bit ASCII; any other character is reported as none of these.
module rec_char_class
    import rec_pkg::*;
(
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib,
    output logic       is_colon,
    output logic       is_eol
);

    // Map the character onto its class and nibble value.
    always_comb begin
        is_hex   = 1'b0;
        nib      = 4'h0;
        is_colon = (ch == CH_COLON);
        is_eol   = (ch == CH_CR) || (ch == CH_LF);
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            nib    = 4'(ch - 8'h30);
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            is_hex = 1'b1;
            nib    = 4'(ch - 8'h37);
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            is_hex = 1'b1;
            nib    = 4'(ch - 8'h57);
        end
    end

endmodule

// File: rtl/rec_line_buf.sv
// Line buffer: pairs nibbles into bytes, stores up to LINE_MAX bytes of one
// record, keeps a running 8-bit sum, and flags an odd digit count or
// overflow. Exposes the header fields and a word-indexed data read port.
// Assumes LINE_MAX >= 6 and that clear is pulsed before each new line.
module rec_line_buf #(
    parameter int LINE_MAX = 21,
    parameter int IDX_W    = $clog2(LINE_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             nib_valid,
    input  logic [3:0]       nib,
    input  logic [IDX_W-1:0] rd_k,
    output logic [IDX_W-1:0] len,
    output logic             odd,
    output logic             over,
    output logic [7:0]       sum,
    output logic [7:0]       hdr_cnt,
    output logic [15:0]      hdr_addr,
    output logic [7:0]       hdr_type,
    output logic [7:0]       rd_lo,
    output logic [7:0]       rd_hi
);

    localparam int DATA_OFS = 4;

    logic [IDX_W-1:0]      idx_q;
    logic                  half_q;
    logic [3:0]            hi_q;
    logic                  over_q;
    logic [7:0]            sum_q;
    logic [LINE_MAX*8-1:0] cells;

    logic       byte_done;
    logic [7:0] byte_in;
    logic       room;

    assign byte_done = nib_valid && half_q;
    assign byte_in   = {hi_q, nib};
    assign room      = idx_q < IDX_W'(LINE_MAX);

    // One byte cell per buffer position, written when the fill index hits it.
    for (genvar g = 0; g < LINE_MAX; g++) begin : g_cell
        logic [7:0] cell_q;
        // Capture the completed byte destined for this position.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= 8'h00;
            else if (byte_done && room && idx_q == IDX_W'(g))
                cell_q <= byte_in;
        end
        assign cells[g*8 +: 8] = cell_q;
    end

    // Track nibble phase, fill index, running sum and overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q  <= '0;
            half_q <= 1'b0;
            hi_q   <= 4'h0;
            over_q <= 1'b0;
            sum_q  <= 8'h00;
        end else if (nib_valid) begin
            half_q <= !half_q;
            if (!half_q) begin
                hi_q <= nib;
            end else if (room) begin
                idx_q <= idx_q + IDX_W'(1);
                sum_q <= sum_q + byte_in;
            end else begin
                over_q <= 1'b1;
            end
        end
    end

    int lo_i;
    int hi_i;

    // Select the low and high byte of data word rd_k.
    always_comb begin
        lo_i  = DATA_OFS + 2 * int'(rd_k);
        hi_i  = lo_i + 1;
        rd_lo = (lo_i < LINE_MAX) ? cells[lo_i*8 +: 8] : 8'h00;
        rd_hi = (hi_i < LINE_MAX) ? cells[hi_i*8 +: 8] : 8'h00;
    end

    assign len      = idx_q;
    assign odd      = half_q;
    assign over     = over_q;
    assign sum      = sum_q;
    assign hdr_cnt  = cells[7:0];
    assign hdr_addr = {cells[15:8], cells[23:16]};
    assign hdr_type = cells[31:24];

    // R7: the fill index never runs past the buffer.
    p_idx_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(LINE_MAX));

endmodule

// File: rtl/rec_word_emit.sv
// Word emitter: walks the data words of an accepted record and offers each
// one with its byte address on a ready/valid port. Addresses below
// VEC_BYTES are moved into the reserved tail at TAIL_BASE.
// Assumes start is pulsed only while idle, with n_words >= 1.
module rec_word_emit #(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 5,
    parameter int VEC_BYTES = 8,
    parameter int TAIL_BASE = 'h7FF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [IDX_W-1:0]  n_words,
    input  logic [ADDR_W-1:0] base,
    input  logic [7:0]        rd_lo,
    input  logic [7:0]        rd_hi,
    input  logic              wr_ready,
    output logic [IDX_W-1:0]  rd_k,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic              done
);

    logic              active_q;
    logic [IDX_W-1:0]  k_q;
    logic [IDX_W-1:0]  last_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] byte_addr;

    // Step through the words, one per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            k_q      <= '0;
            last_q   <= '0;
            base_q   <= '0;
        end else if (abort) begin
            active_q <= 1'b0;
            k_q      <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            k_q      <= '0;
            last_q   <= n_words - IDX_W'(1);
            base_q   <= base;
        end else if (active_q && wr_ready) begin
            if (k_q == last_q) begin
                active_q <= 1'b0;
                k_q      <= '0;
            end else begin
                k_q <= k_q + IDX_W'(1);
            end
        end
    end

    // Form the byte address of the current word and relocate the vector area.
    always_comb begin
        byte_addr = base_q + ADDR_W'({k_q, 1'b0});
        if (byte_addr < ADDR_W'(VEC_BYTES))
            wr_addr = ADDR_W'(TAIL_BASE) + byte_addr;
        else
            wr_addr = byte_addr;
    end

    assign rd_k     = k_q;
    assign wr_valid = active_q;
    assign wr_data  = {rd_hi, rd_lo};
    assign done     = active_q && wr_ready && (k_q == last_q) && !abort;

    // R4: an offered word holds still until the engine takes it.
    p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready && !abort |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R4: a new record never starts over one still being sent.
    p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active_q);

endmodule

// File: rtl/rec_ingest.sv
// HEX record receiver: frames ':'-led ASCII lines, buffers them, validates
// shape, checksum, type and target range, then sends data words to a
// programming engine while holding the host off with clear-to-send.
// Assumes one character per rx_valid cycle and a 16-bit record address.
module rec_ingest
    import rec_pkg::*;
#(
    parameter int DATA_MAX    = 16,
    parameter int ADDR_W      = 16,
    parameter int LOADER_BASE = 'h7C5C,
    parameter int TAIL_BASE   = 'h7FF8,
    parameter int VEC_BYTES   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_overrun,
    input  logic              host_rts,
    output logic              cts,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic [15:0]       ext_hi,
    output logic              eof_done,
    output logic [2:0]        err_code,
    output logic [ADDR_W-1:0] err_addr,
    output logic              halted
);

    localparam int LINE_MAX = DATA_MAX + 5;
    localparam int IDX_W    = $clog2(LINE_MAX + 1);

    rec_state_e        state_q;
    rec_err_e          err_q;
    rec_err_e          eol_err;
    logic [ADDR_W-1:0] err_addr_q;
    logic              eof_q;
    logic [15:0]       ext_q;

    logic             is_hex, is_colon, is_eol;
    logic [3:0]       nib;
    logic [IDX_W-1:0] len;
    logic             odd, over;
    logic [7:0]       sum, hdr_cnt, hdr_type, rd_lo, rd_hi;
    logic [15:0]      hdr_addr;
    logic [IDX_W-1:0] rd_k;
    logic             emit_done;

    logic [8:0]  want_len;
    logic [16:0] last_b;
    logic        shape_bad, type_bad, ovw;
    logic        take, nib_valid, buf_clear, eol_fire, emit_start;

    rec_char_class u_class (
        .ch       (rx_data),
        .is_hex   (is_hex),
        .nib      (nib),
        .is_colon (is_colon),
        .is_eol   (is_eol)
    );

    assign take       = rx_valid && !rx_overrun;
    assign buf_clear  = (state_q == ST_IDLE) && take && is_colon;
    assign nib_valid  = (state_q == ST_LINE) && take && is_hex;
    assign eol_fire   = (state_q == ST_LINE) && take && is_eol;
    assign emit_start = eol_fire && (eol_err == ERR_NONE) &&
                        (hdr_type == TYP_DATA) && (hdr_cnt != 8'h00);

    rec_line_buf #(
        .LINE_MAX (LINE_MAX),
        .IDX_W    (IDX_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .nib_valid (nib_valid),
        .nib       (nib),
        .rd_k      (rd_k),
        .len       (len),
        .odd       (odd),
        .over      (over),
        .sum       (sum),
        .hdr_cnt   (hdr_cnt),
        .hdr_addr  (hdr_addr),
        .hdr_type  (hdr_type),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi)
    );

    rec_word_emit #(
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .VEC_BYTES (VEC_BYTES),
        .TAIL_BASE (TAIL_BASE)
    ) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (emit_start),
        .abort    (rx_overrun),
        .n_words  (IDX_W'(hdr_cnt[7:1])),
        .base     (ADDR_W'(hdr_addr)),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .wr_ready (wr_ready),
        .rd_k     (rd_k),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .done     (emit_done)
    );

    // Judge a closed line: shape first, then checksum, type rules and range.
    always_comb begin
        want_len  = 9'(hdr_cnt) + 9'd5;
        shape_bad = odd || over || (len < IDX_W'(5)) || (9'(len) != want_len);
        last_b    = 17'(hdr_addr) + 17'(hdr_cnt) - 17'd1;
        ovw       = 1'b0;
        case (hdr_type)
            TYP_DATA: begin
                type_bad = hdr_addr[0] || hdr_cnt[0];
                ovw      = (hdr_cnt != 8'h00) && (last_b >= 17'(LOADER_BASE));
            end
            TYP_EOF: type_bad = (hdr_cnt != 8'h00);
            TYP_EXT: type_bad = (hdr_cnt != 8'h02);
            default: type_bad = 1'b1;
        endcase
        if (shape_bad)
            eol_err = ERR_FMT;
        else if (sum != 8'h00)
            eol_err = ERR_CSUM;
        else if (type_bad)
            eol_err = ERR_FMT;
        else if (ovw)
            eol_err = ERR_OVW;
        else
            eol_err = ERR_NONE;
    end

    // Control sequence: framing, record dispatch, error capture and halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            err_q      <= ERR_NONE;
            err_addr_q <= '0;
            eof_q      <= 1'b0;
            ext_q      <= 16'h0000;
        end else if (state_q != ST_HALT && rx_overrun) begin
            state_q    <= ST_HALT;
            err_q      <= ERR_OVR;
            err_addr_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (rx_valid && is_colon) state_q <= ST_LINE;
                ST_LINE: if (rx_valid) begin
                    if (is_eol) begin
                        if (eol_err != ERR_NONE) begin
                            state_q    <= ST_HALT;
                            err_q      <= eol_err;
                            err_addr_q <= (eol_err == ERR_FMT) ? '0 : ADDR_W'(hdr_addr);
                        end else if (hdr_type == TYP_EOF) begin
                            state_q <= ST_EOF;
                            eof_q   <= 1'b1;
                        end else if (hdr_type == TYP_EXT) begin
                            state_q <= ST_IDLE;
                            ext_q   <= {rd_lo, rd_hi};
                        end else if (hdr_cnt != 8'h00) begin
                            state_q <= ST_EMIT;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else if (!is_hex) begin
                        state_q    <= ST_HALT;
                        err_q      <= ERR_FMT;
                        err_addr_q <= '0;
                    end
                end
                ST_EMIT: if (emit_done) state_q <= ST_IDLE;
                default: ;
            endcase
        end
    end

    assign cts      = host_rts && (state_q == ST_IDLE || state_q == ST_LINE);
    assign eof_done = eof_q;
    assign ext_hi   = ext_q;
    assign err_code = err_q;
    assign err_addr = err_addr_q;
    assign halted   = (state_q == ST_HALT);

    // R8: the host is held off whenever a word is on offer.
    p_busy_no_cts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !cts);

    // R11: a halted block offers nothing and grants nothing.
    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !wr_valid && !cts);

    // R11: an overrun outside halt ends in the overrun code.
    p_overrun_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun && !halted |=> halted && err_code == 3'd4);

    // R12: the halt and its code persist.
    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(err_code) && $stable(err_addr));

    // R6: no word ever lands in the loader area below the tail.
    p_no_loader_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr < ADDR_W'(LOADER_BASE)) || (wr_addr >= ADDR_W'(TAIL_BASE)));

endmodule

// File: tb/tb_rec_ingest.sv
module tb_rec_ingest;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_overrun = 1'b0;
    logic        host_rts = 1'b1;
    logic        cts;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic [15:0] ext_hi;
    logic        eof_done;
    logic [2:0]  err_code;
    logic [15:0] err_addr;
    logic        halted;

    int checks = 0;
    int errs = 0;
    int ready_mode = 0;
    int cyc = 0;

    logic [7:0]  dbytes [32];
    logic [15:0] exp_a [16];
    logic [15:0] exp_d [16];
    int          exp_n;
    logic [15:0] got_a [64];
    logic [15:0] got_d [64];
    int          got_n = 0;

    rec_ingest dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_overrun(rx_overrun), .host_rts(host_rts), .cts(cts),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_hi(ext_hi), .eof_done(eof_done),
        .err_code(err_code), .err_addr(err_addr), .halted(halted)
    );

    always #10 clk = !clk;

    // Drive ready for the coming edge, then log the transfer that edge makes.
    always @(negedge clk) begin
        cyc++;
        wr_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;
        if (wr_valid && wr_ready && got_n < 64) begin
            got_a[got_n] = wr_addr;
            got_d[got_n] = wr_data;
            got_n++;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + 8'(n);
        return (lower ? 8'h57 : 8'h37) + 8'(n);
    endfunction

    task automatic send_char(input logic [7:0] c);
        rx_valid = 1'b1;
        rx_data  = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_rec(input logic [7:0] cnt, input logic [15:0] addr, input logic [7:0] typ,
                            input int ndat, input bit bad_sum, input bit lower);
        logic [7:0] b [40];
        logic [7:0] s = 8'h00;
        int nb = 4 + ndat;
        b[0] = cnt; b[1] = addr[15:8]; b[2] = addr[7:0]; b[3] = typ;
        for (int i = 0; i < ndat; i++) b[4+i] = dbytes[i];
        for (int i = 0; i < nb; i++) s += b[i];
        b[nb] = (8'h00 - s) ^ (bad_sum ? 8'h01 : 8'h00);
        send_char(8'h3A);
        for (int i = 0; i <= nb; i++) begin
            send_char(hexch(b[i][7:4], lower));
            send_char(hexch(b[i][3:0], lower));
        end
        send_char(8'h0D);
        send_char(8'h0A);
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 500; i++) begin
            if ((cts && !wr_valid) || halted || eof_done) break;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        got_n = 0;
    endtask

    task automatic fill(input int a, input int n);
        for (int i = 0; i < 32; i++) dbytes[i] = 8'(a + i * 37 + n * 11);
        exp_n = n / 2;
        for (int k = 0; k < exp_n; k++) begin
            exp_a[k] = (a + 2 * k < 8) ? 16'(32'h7FF8 + a + 2 * k) : 16'(a + 2 * k);
            exp_d[k] = {dbytes[2*k+1], dbytes[2*k]};
        end
    endtask

    task automatic compare_words();
        chk("R4", "word count", got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            if (exp_a[k] >= 16'h7FF8) chk("R5", "relocated addr", got_a[k], exp_a[k]);
            else                      chk("R4", "word addr", got_a[k], exp_a[k]);
            chk("R4", "word data", got_d[k], exp_d[k]);
        end
    endtask

    task automatic fault_case(input string req, input logic [7:0] cnt, input logic [15:0] addr,
                              input logic [7:0] typ, input int ndat, input bit bad,
                              input logic [2:0] ecode, input logic [15:0] eaddr);
        do_reset();
        fill(addr, ndat);
        send_rec(cnt, addr, typ, ndat, bad, 1'b0);
        wait_idle();
        chk(req, "err_code", err_code, ecode);
        chk(req, "err_addr", err_addr, eaddr);
        chk(req, "halted", halted, 1'b1);
        chk(req, "no words", got_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        int addrs [6] = '{0, 4, 8, 'h100, 'h2ABC, 'h7C4A};
        int run = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cts", cts, 1'b1);
        chk("R1", "wr_valid", wr_valid, 1'b0);
        chk("R1", "err_code", err_code, 3'd0);
        chk("R1", "eof_done", eof_done, 1'b0);
        chk("R1", "halted", halted, 1'b0);
        host_rts = 1'b0;
        #1 chk("R1", "cts follows rts", cts, 1'b0);
        host_rts = 1'b1;
        @(negedge clk);

        // R2 noise outside a record is ignored
        send_char(8'h0D); send_char(8'h0A); send_char("x"); send_char("7");
        @(negedge clk);
        chk("R2", "noise err", err_code, 3'd0);
        chk("R2", "noise cts", cts, 1'b1);

        // R4/R5 sweep of start addresses and lengths, two ready patterns
        foreach (addrs[ai]) begin
            for (int n = 0; n <= 16; n += 2) begin
                ready_mode = run % 2;
                got_n = 0;
                fill(addrs[ai], n);
                send_rec(8'(n), 16'(addrs[ai]), 8'h00, n, 1'b0, run[2]);
                wait_idle();
                chk("R2", "sweep err", err_code, 3'd0);
                compare_words();
                run++;
            end
        end
        ready_mode = 0;

        // R6 boundary: a record ending just below the loader is accepted
        got_n = 0;
        fill('h7C58, 4);
        send_rec(8'd4, 16'h7C58, 8'h00, 4, 1'b0, 1'b0);
        wait_idle();
        chk("R6", "edge accepted", err_code, 3'd0);
        compare_words();

        // R8 hold-off while the engine stalls; characters then are ignored
        ready_mode = 2;
        got_n = 0;
        fill('h200, 4);
        send_rec(8'd4, 16'h0200, 8'h00, 4, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R8", "cts while busy", cts, 1'b0);
        chk("R8", "valid while busy", wr_valid, 1'b1);
        send_char(8'h3A); send_char("G"); send_char(8'h0D);
        ready_mode = 0;
        wait_idle();
        chk("R8", "busy chars ignored", err_code, 3'd0);
        chk("R8", "cts restored", cts, 1'b1);
        compare_words();
        got_n = 0;
        fill('h300, 2);
        send_rec(8'd2, 16'h0300, 8'h00, 2, 1'b0, 1'b0);
        wait_idle();
        compare_words();

        // R10 upper address record
        dbytes[0] = 8'h12; dbytes[1] = 8'h34;
        send_rec(8'd2, 16'h0000, 8'h04, 2, 1'b0, 1'b0);
        wait_idle();
        chk("R10", "ext_hi", ext_hi, 16'h1234);
        chk("R10", "cts after ext", cts, 1'b1);

        // R9 end of file
        send_rec(8'd0, 16'h0000, 8'h01, 0, 1'b0, 1'b0);
        wait_idle();
        chk("R9", "eof_done", eof_done, 1'b1);
        chk("R9", "cts after eof", cts, 1'b0);
        chk("R9", "eof err", err_code, 3'd0);

        // R3 checksum, R6 overwrite, R7 format faults
        fault_case("R3", 8'd4, 16'h1230, 8'h00, 4, 1'b1, 3'd1, 16'h1230);
        fault_case("R6", 8'd4, 16'h7C5A, 8'h00, 4, 1'b0, 3'd3, 16'h7C5A);
        fault_case("R6", 8'd2, 16'h7FF8, 8'h00, 2, 1'b0, 3'd3, 16'h7FF8);
        fault_case("R7", 8'd18, 16'h0100, 8'h00, 18, 1'b0, 3'd2, 16'h0000);
        fault_case("R7", 8'd4, 16'h0100, 8'h00, 2, 1'b0, 3'd2, 16'h0000);
        fault_case("R7", 8'd0, 16'h0000, 8'h02, 0, 1'b0, 3'd2, 16'h0000);
        fault_case("R7", 8'd2, 16'h0101, 8'h00, 2, 1'b0, 3'd2, 16'h0000);
        fault_case("R7", 8'd1, 16'h0000, 8'h01, 1, 1'b0, 3'd2, 16'h0000);

        // R7 non-hex character inside a record faults at once
        do_reset();
        send_char(8'h3A); send_char("0"); send_char("0"); send_char("G");
        @(negedge clk);
        chk("R7", "non-hex err", err_code, 3'd2);
        chk("R7", "non-hex halt", halted, 1'b1);

        // R7 odd digit count
        do_reset();
        send_char(8'h3A);
        for (int i = 0; i < 9; i++) send_char("0");
        send_char(8'h0D);
        @(negedge clk);
        chk("R7", "odd digits err", err_code, 3'd2);

        // R11 overrun mid-line, R12 halt persists
        do_reset();
        send_char(8'h3A); send_char("0"); send_char("2");
        rx_overrun = 1'b1;
        @(negedge clk);
        rx_overrun = 1'b0;
        @(negedge clk);
        chk("R11", "overrun err", err_code, 3'd4);
        chk("R11", "overrun halt", halted, 1'b1);
        chk("R11", "overrun cts", cts, 1'b0);
        fill('h400, 2);
        send_rec(8'd2, 16'h0400, 8'h00, 2, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R12", "still overrun", err_code, 3'd4);
        chk("R12", "no words", got_n, 0);
        chk("R12", "no valid", wr_valid, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule